// File: doc/BRIEF.md
# Cache Activity Statistics Bank

This block keeps a set of event counters beside a cache. The cache core and its maintenance sequencer each send single-cycle pulses on an event vector: read and write accesses, read and write hits, misaligned reads and writes, line flushes and line replacements. Every asserted bit adds one to its own counter in the same clock cycle. A collect-enable input freezes all counting while it is low. A clear pulse zeroes the whole bank.

Software or a debug agent reads the bank through a small request/response port, one register per request. Both halves use a valid/ready handshake. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from that acceptance until the response has been consumed, so only one read is ever in flight. The response stays valid with stable data until `rsp_ready` is seen high.

Two addresses return hit rates rather than raw counts. A request to one of them starts a shift-subtract divider on a snapshot of the hit and access counts. The response becomes valid when the divider finishes, so `rsp_valid` also serves as its done flag.

Top module: `cache_stat_bank`

## Requirements
- R1: Event bit k of `evt` adds one to counter k on each clock edge where it is high, with the collect enable high and no clear. The bits are: 0 read access, 1 write access, 2 misaligned read, 3 misaligned write, 4 flush, 5 replacement, 6 read hit, 7 write hit. Counter k is read at address k (0 to 7).
- R2: Any number of event bits high in the same cycle each advance their own counter in that cycle.
- R3: A counter that holds its all-ones value stays there on further events. It does not wrap.
- R4: While `stat_en` is low, no counter changes, whatever the events.
- R5: A cycle with `stat_clr` high sets every counter to zero. Clear takes priority over events in the same cycle.
- R6: After reset every counter reads zero, both hit rates read zero, and `rsp_valid` is low.
- R7: Address 8 returns the read hit rate, floor(read hits × 100 / read accesses). Address 9 returns the write hit rate, built the same way from write hits and write accesses. A rate reads 0 when its access count is zero, and reads 100 when hits exceed accesses.
- R8: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low while a response is pending. `rsp_valid` and `rsp_data` hold steady until `rsp_ready` is high.
- R9: Addresses 10 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_en | input | 1 | Collect enable; counting stops while low |
| stat_clr | input | 1 | Synchronous clear of all counters |
| evt | input | 8 | Event pulses, one bit per counter |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request can be accepted |
| req_addr | input | 4 | Register address of the request |
| rsp_valid | output | 1 | Read data valid (also divider done) |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_data | output | CNT_W | Counter value or percentage, zero-extended |

## Verification
The assertions assume events arrive only as level samples at the clock edge, and that `stat_clr` and the events may overlap freely; the stimulus drives both on falling edges and includes a clear cycle with every event bit set. The assertions also assume the consumer may stall: the response-hold property only makes sense if `rsp_ready` can stay low, and the stimulus holds it low for several cycles in one test. Reads are issued only after the event stream has gone quiet, so each snapshot matches a count the bench can compute.

// File: rtl/cstat_pkg.sv
package cstat_pkg;
  localparam int NUM_EVT = 8;
  localparam int ADDR_W  = 4;

  typedef enum logic [2:0] {
    EV_RD_ACC  = 3'd0,
    EV_WR_ACC  = 3'd1,
    EV_RD_MIS  = 3'd2,
    EV_WR_MIS  = 3'd3,
    EV_FLUSH   = 3'd4,
    EV_REPL    = 3'd5,
    EV_RD_HIT  = 3'd6,
    EV_WR_HIT  = 3'd7
  } evt_idx_e;

  localparam logic [ADDR_W-1:0] A_RD_RATE = 4'd8;
  localparam logic [ADDR_W-1:0] A_WR_RATE = 4'd9;

  typedef enum logic [1:0] {
    RP_IDLE = 2'd0,
    RP_DIV  = 2'd1,
    RP_RESP = 2'd2
  } rp_state_e;
endpackage

// File: rtl/cstat_counter.sv
module cstat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic at_max;
  assign at_max = (cnt == MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (en && inc && !at_max) cnt <= cnt + W'(1);
  end

  // R1: an accepted event advances by exactly one
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && en && !clr && !at_max) |=> (cnt == $past(cnt) + W'(1)));
  // R3: no wrap past all-ones
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !clr) |=> (cnt == MAXV));
  // R4: frozen while collection disabled
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt));
  // R5: clear wins
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/cstat_pct_div.sv
module cstat_pct_div #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] hits,
  input  logic [CNT_W-1:0] accs,
  output logic             busy,
  output logic             done,
  output logic [6:0]       pct
);
  localparam int NW  = CNT_W + 7;
  localparam int ITW = $clog2(NW + 1);

  logic [NW-1:0]    num_sh;
  logic [NW-1:0]    quo;
  logic [CNT_W:0]   rem;
  logic [CNT_W-1:0] den;
  logic             den_zero;
  logic [ITW-1:0]   it_left;
  logic [CNT_W:0]   rem_sh;
  logic             take;

  assign rem_sh = {rem[CNT_W-1:0], num_sh[NW-1]};
  assign take   = (rem_sh >= {1'b0, den});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_sh   <= '0;
      quo      <= '0;
      rem      <= '0;
      den      <= '0;
      den_zero <= 1'b0;
      it_left  <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        num_sh   <= NW'(hits) * NW'(100);
        den      <= accs;
        den_zero <= (accs == '0);
        quo      <= '0;
        rem      <= '0;
        it_left  <= ITW'(NW);
        busy     <= 1'b1;
      end else if (busy) begin
        num_sh  <= {num_sh[NW-2:0], 1'b0};
        quo     <= {quo[NW-2:0], take};
        rem     <= take ? (rem_sh - {1'b0, den}) : rem_sh;
        it_left <= it_left - ITW'(1);
        if (it_left == ITW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (den_zero)                 pct = 7'd0;
    else if (quo > NW'(100))      pct = 7'd100;
    else                          pct = quo[6:0];
  end

  // R7: completion is a single pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: a start is never issued during a running division
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/cache_stat_bank.sv
module cache_stat_bank
  import cstat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stat_en,
  input  logic               stat_clr,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [CNT_W-1:0]   rsp_data
);
  localparam int SEL_W = $clog2(NUM_EVT);

  logic [CNT_W-1:0] cnt_q [NUM_EVT];

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_cnt
    cstat_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (stat_clr),
      .en   (stat_en),
      .inc  (evt[k]),
      .cnt  (cnt_q[k])
    );
  end

  rp_state_e        st;
  logic             accept;
  logic             is_cnt;
  logic             is_rate;
  logic             div_start;
  logic             div_busy;
  logic             div_done;
  logic [6:0]       div_pct;
  logic [CNT_W-1:0] div_hits;
  logic [CNT_W-1:0] div_accs;
  logic             rsp_is_rate;

  assign req_ready = (st == RP_IDLE);
  assign rsp_valid = (st == RP_RESP);
  assign accept    = req_valid && req_ready;
  assign is_cnt    = (req_addr < ADDR_W'(NUM_EVT));
  assign is_rate   = (req_addr == A_RD_RATE) || (req_addr == A_WR_RATE);
  assign div_start = accept && is_rate;

  always_comb begin
    if (req_addr == A_RD_RATE) begin
      div_hits = cnt_q[EV_RD_HIT];
      div_accs = cnt_q[EV_RD_ACC];
    end else begin
      div_hits = cnt_q[EV_WR_HIT];
      div_accs = cnt_q[EV_WR_ACC];
    end
  end

  cstat_pct_div #(.CNT_W(CNT_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .start(div_start),
    .hits (div_hits),
    .accs (div_accs),
    .busy (div_busy),
    .done (div_done),
    .pct  (div_pct)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= RP_IDLE;
      rsp_data    <= '0;
      rsp_is_rate <= 1'b0;
    end else begin
      unique case (st)
        RP_IDLE: if (accept) begin
          rsp_is_rate <= is_rate;
          if (is_rate) begin
            st <= RP_DIV;
          end else begin
            rsp_data <= is_cnt ? cnt_q[req_addr[SEL_W-1:0]] : '0;
            st       <= RP_RESP;
          end
        end
        RP_DIV: if (div_done) begin
          rsp_data <= CNT_W'(div_pct);
          st       <= RP_RESP;
        end
        RP_RESP: if (rsp_ready) st <= RP_IDLE;
        default: st <= RP_IDLE;
      endcase
    end
  end

  // R8: a stalled response keeps its data
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R8: no new request while one is outstanding
  p_one_inflight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || div_busy) |-> !req_ready);
  // R7: a rate never exceeds one hundred
  p_rate_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_is_rate) |-> (rsp_data <= CNT_W'(100)));
endmodule

// File: tb/cache_stat_bank_bench.sv
`timescale 1ns/1ps
module cache_stat_bank_bench;
  localparam int CW   = 8;
  localparam int MAXC = 255;

  typedef struct packed {
    logic [7:0] evt;
    logic [8:0] reps;
    logic       en;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h01, 9'd3, 1'b1},
    '{8'h41, 9'd2, 1'b1},
    '{8'hFF, 9'd1, 1'b1},
    '{8'h82, 9'd4, 1'b1},
    '{8'h3C, 9'd5, 1'b0},
    '{8'h30, 9'd2, 1'b1},
    '{8'h0C, 9'd3, 1'b1},
    '{8'hC0, 9'd7, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stat_en = 1'b1;
  logic          stat_clr = 1'b0;
  logic [7:0]    evt = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [3:0]    req_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [CW-1:0] rsp_data;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit ended = 0;
  int mdl [8];

  always #2.5 clk = ~clk;

  cache_stat_bank #(.CNT_W(CW)) u_cache_stat_bank (
    .clk(clk), .rst_n(rst_n), .stat_en(stat_en), .stat_clr(stat_clr),
    .evt(evt), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data)
  );

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nchk++; nfail++;
        $display("FAIL watchdog: actual=hung expected=finish");
        finish_run();
      end
    end
  end

  task automatic check(input string req, input int actual, input int expv);
    nchk++;
    if (actual != expv) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expv);
    end
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = int'(rsp_data);
  endtask

  function automatic int rate(input int h, input int acc);
    int r;
    if (acc == 0) return 0;
    r = (h * 100) / acc;
    return (r > 100) ? 100 : r;
  endfunction

  task automatic pulse(input logic [7:0] e, input int n);
    @(negedge clk);
    evt = e;
    for (int i = 0; i < n; i++) @(negedge clk);
    evt = '0;
  endtask

  task automatic check_all(input string tag);
    int d;
    for (int k = 0; k < 8; k++) begin
      rd(4'(k), d);
      check(tag, d, mdl[k]);
    end
    rd(4'd8, d);
    check("R7 read rate", d, rate(mdl[6], mdl[0]));
    rd(4'd9, d);
    check("R7 write rate", d, rate(mdl[7], mdl[1]));
  endtask

  initial begin
    int d;
    for (int k = 0; k < 8; k++) mdl[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 rsp_valid", int'(rsp_valid), 0);
    check_all("R6 reset count");

    for (int v = 0; v < 8; v++) begin
      stat_en = VECS[v].en;
      pulse(VECS[v].evt, int'(VECS[v].reps));
      @(negedge clk);
      stat_en = 1'b1;
      for (int b = 0; b < 8; b++)
        if (VECS[v].en && VECS[v].evt[b]) begin
          mdl[b] = mdl[b] + int'(VECS[v].reps);
          if (mdl[b] > MAXC) mdl[b] = MAXC;
        end
      if (!VECS[v].en)                       check_all("R4 gated count");
      else if ($countones(VECS[v].evt) > 1)  check_all("R2 multi-event count");
      else                                   check_all("R1 count");
    end

    // R5: clear with all events high in the same cycle
    @(negedge clk);
    stat_clr = 1'b1;
    evt = 8'hFF;
    @(negedge clk);
    stat_clr = 1'b0;
    evt = '0;
    for (int k = 0; k < 8; k++) mdl[k] = 0;
    check_all("R5 cleared count");

    // R3: saturation
    pulse(8'h01, 300);
    rd(4'd0, d);
    check("R3 saturated", d, MAXC);
    pulse(8'h01, 2);
    rd(4'd0, d);
    check("R3 stays at max", d, MAXC);
    rd(4'd8, d);
    check("R7 zero hits", d, 0);

    // R9: unmapped addresses
    rd(4'd10, d);
    check("R9 addr 10", d, 0);
    rd(4'd15, d);
    check("R9 addr 15", d, 0);

    // R8: stalled response
    @(negedge clk);
    rsp_ready = 1'b0;
    rd(4'd0, d);
    check("R8 data", d, MAXC);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R8 valid held", int'(rsp_valid), 1);
      check("R8 data held", int'(rsp_data), MAXC);
      check("R8 ready low", int'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R8 released", int'(rsp_valid), 0);
    check("R8 ready again", int'(req_ready), 1);

    finish_run();
  end
endmodule